// File: doc/BRIEF.md
# One-Time-Programmable Program Memory Programming Port

This block is the device-side logic of the programming interface for a one-time-programmable program store of 16-bit words. It has no address pins. A word counter inside the block supplies the location, and only an external programming strobe moves it. Each word takes four strobe pulses. The 16-bit word travels as two bytes over an 8-bit data path: the low byte during pulses one and two, and the high byte during pulses three and four.

A 4-bit mode input selects one of four operations:
- clearing the counter to zero,
- writing (programming),
- reading or verifying,
- inhibit.

The strobe comes from outside the system clock domain. It passes through a two-stage synchronizer, and the block acts on its falling edges. The counter steps on the third falling edge of each word cycle. Writes can only turn erased ones into zeros. The storage is a plain register array that powers up erased.

Top module: `otp_prog_port`

## Requirements
- R1: While reset is asserted, `pd_oe` is 0, the word counter is zero and every stored word reads 16'hFFFF.
- R2: Mode 4'h1 (clear) forces the word counter and the pulse phase to zero on every clock while it is selected, including in the middle of a word cycle.
- R3: The strobe is sampled by two flops. When the strobe is first sampled low after being high on the edge before, the resulting falling edge acts on the second clock edge after that sample.
- R4: In write and read modes, every falling strobe edge advances the phase 0→1→2→3→0. The word counter increments on the falling edge that moves the phase from 2 to 3, which is the third falling edge of the cycle.
- R5: In read mode (4'h3), while `pd_oe` is 1, `pd_out` carries bits 7:0 of the current cycle's word at phases 0 and 1, and bits 15:8 at phases 2 and 3. The current cycle's word is the one at the counter value held at phase 0.
- R6: In write mode (4'h2), `pd_in` is captured as the low byte at the falling edge from phase 1 to 2. At the falling edge from phase 3 to 0, `{pd_in, low byte}` is ANDed into the current cycle's word, so a stored bit can only go from 1 to 0.
- R7: `pd_oe` is 1 exactly one clock after mode 4'h3 is present on a clock edge, and 0 otherwise. When `pd_oe` is 0, `pd_out` is 8'h00.
- R8: In mode 4'h0 (inhibit), and in every unused encoding (4'h4 to 4'hF), strobe pulses change neither the counter, the phase nor the memory.
- R9: The word counter wraps from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgm_clk | input | 1 | External programming strobe, asynchronous |
| mode | input | 4 | Operation select: 0 inhibit, 1 clear, 2 write, 3 read |
| pd_in | input | 8 | Byte from the data pad |
| pd_out | output | 8 | Byte to the data pad |
| pd_oe | output | 1 | Pad driver enable; pad is high-impedance when 0 |

## Verification
The strobe edge that increments the counter is also an edge on which a write may commit or a byte lane may change. The write that lands on the fourth edge must therefore use the cycle's starting address, not the address the counter already moved to on the third edge. The bench programs consecutive words, reads them back and rewrites an already-programmed word, so that counter steps, lane switches and AND-writes fall on neighbouring edges. A behavioural model is compared with `pd_oe` and `pd_out` on every clock. A clear issued in the middle of a cycle, and a wrap past the last location, show whether the phase and the counter are kept apart correctly.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [3:0] {
        MD_INHIBIT = 4'h0,
        MD_CLEAR   = 4'h1,
        MD_WRITE   = 4'h2,
        MD_READ    = 4'h3
    } otp_mode_e;

    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int PHASES  = 4;
    localparam int PHASE_W = $clog2(PHASES);
endpackage

// File: rtl/otp_pclk_sync.sv
module otp_pclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pgm_clk,
    output logic fall
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pgm_clk};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

    // R3: an edge is reported for a single clock only
    assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/otp_word_seq.sv
module otp_word_seq
    import otp_pkg::*;
#(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fall,
    input  logic [3:0]         mode,
    input  logic [BYTE_W-1:0]  pd_in,
    output logic [AW-1:0]      word_addr,
    output logic               wr_en,
    output logic [WORD_W-1:0]  wr_data,
    output logic               lane_hi,
    output logic               oe
);
    typedef struct packed {
        logic [AW-1:0]      addr;
        logic [PHASE_W-1:0] phase;
        logic [BYTE_W-1:0]  lo;
        logic               oe;
    } seq_t;

    localparam logic [AW-1:0]      LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [PHASE_W-1:0] PH_LO_END = PHASE_W'(1);
    localparam logic [PHASE_W-1:0] PH_STEP   = PHASE_W'(2);
    localparam logic [PHASE_W-1:0] PH_LAST   = PHASE_W'(PHASES - 1);

    seq_t st_d, st_q;
    logic is_clear, is_write, is_read, active, step;
    logic [AW-1:0] addr_inc, addr_prev;

    always_comb begin
        is_clear  = (mode == MD_CLEAR);
        is_write  = (mode == MD_WRITE);
        is_read   = (mode == MD_READ);
        active    = is_write | is_read;
        step      = active & fall;
        addr_inc  = (st_q.addr == LAST_ADDR) ? '0 : st_q.addr + AW'(1);
        addr_prev = (st_q.addr == '0) ? LAST_ADDR : st_q.addr - AW'(1);

        st_d    = st_q;
        st_d.oe = is_read;
        if (is_clear) begin
            st_d.addr  = '0;
            st_d.phase = '0;
        end else if (step) begin
            st_d.phase = st_q.phase + PHASE_W'(1);
            if (st_q.phase == PH_STEP) st_d.addr = addr_inc;
            if (is_write && st_q.phase == PH_LO_END) st_d.lo = pd_in;
        end

        word_addr = (st_q.phase == PH_LAST) ? addr_prev : st_q.addr;
        wr_en     = step & is_write & (st_q.phase == PH_LAST);
        wr_data   = {pd_in, st_q.lo};
        lane_hi   = st_q.phase[PHASE_W-1];
        oe        = st_q.oe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_CLEAR) |=> (st_q.addr == '0 && st_q.phase == '0));

    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && mode != MD_CLEAR) |=> $stable(st_q.phase) && $stable(st_q.addr));

    assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_CLEAR && mode != MD_WRITE && mode != MD_READ)
            |=> $stable(st_q.phase) && $stable(st_q.addr));

    assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && (mode == MD_WRITE || mode == MD_READ) && st_q.phase == PH_STEP
            && st_q.addr == LAST_ADDR) |=> (st_q.addr == '0));
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (wr_en) begin
            cells[addr] <= cells[addr] & wr_data;
        end
    end

    assign rd_data = cells[addr];

    // R6: at a fixed address no bit ever returns from 0 to 1
    assert_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == $past(addr)) |-> ((rd_data & ~$past(rd_data)) == '0));
endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
    import otp_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pgm_clk,
    input  logic [3:0] mode,
    input  logic [7:0] pd_in,
    output logic [7:0] pd_out,
    output logic       pd_oe
);
    localparam int AW = $clog2(DEPTH);

    logic              fall, wr_en, lane_hi, oe;
    logic [AW-1:0]     word_addr;
    logic [WORD_W-1:0] wr_data, rd_data;

    otp_pclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pgm_clk(pgm_clk), .fall(fall));

    otp_word_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .fall(fall), .mode(mode), .pd_in(pd_in),
        .word_addr(word_addr), .wr_en(wr_en), .wr_data(wr_data),
        .lane_hi(lane_hi), .oe(oe));

    otp_cell_array #(.DEPTH(DEPTH)) u_cells (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(word_addr),
        .wr_data(wr_data), .rd_data(rd_data));

    assign pd_oe  = oe;
    assign pd_out = !oe ? '0 : (lane_hi ? rd_data[15:8] : rd_data[7:0]);

    assert_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_READ) |=> pd_oe);
    assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_READ) |=> (!pd_oe && pd_out == 8'h00));
endmodule

// File: tb/otp_prog_port_test.sv
module otp_prog_port_test;
    localparam int D = 40;

    logic       clk = 0, rst_n = 0, pgm_clk = 0;
    logic [3:0] mode = 4'h0;
    logic [7:0] pd_in = 8'h00;
    logic [7:0] pd_out;
    logic       pd_oe;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    otp_prog_port #(.DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .pgm_clk(pgm_clk), .mode(mode),
        .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe));

    // behavioural reference model
    logic [15:0] m_mem [D];
    int m_addr, m_cw, m_ph;
    logic [7:0] m_lo;
    bit m_oe;
    bit h1, h2, h3;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) m_mem[i] = 16'hFFFF;
            m_addr = 0; m_cw = 0; m_ph = 0; m_lo = 0; m_oe = 0;
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            bit f;
            f = h3 && !h2;           // R3 two-stage sample then edge
            m_oe = (mode == 4'h3);
            if (mode == 4'h1) begin
                m_addr = 0; m_ph = 0; m_cw = 0;
            end else if ((mode == 4'h2 || mode == 4'h3) && f) begin
                if (mode == 4'h2 && m_ph == 1) m_lo = pd_in;
                if (mode == 4'h2 && m_ph == 3) m_mem[m_cw] = m_mem[m_cw] & {pd_in, m_lo};
                if (m_ph == 2) m_addr = (m_addr == D - 1) ? 0 : m_addr + 1;
                m_ph = (m_ph + 1) % 4;
                if (m_ph == 0) m_cw = m_addr;
            end
            h3 = h2; h2 = h1; h1 = pgm_clk;
        end
    end

    // every-clock comparison: R3 R4 R5 R7
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [7:0] e;
            e = !m_oe ? 8'h00 : (m_ph < 2 ? m_mem[m_cw][7:0] : m_mem[m_cw][15:8]);
            total++;
            if (pd_oe !== m_oe || pd_out !== e) begin
                bad++;
                $display("FAIL R5/R7 cycle compare: oe=%0b out=%h expected oe=%0b out=%h",
                         pd_oe, pd_out, m_oe, e);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) pgm_clk = 1;
        repeat (5) @(negedge clk);
        pgm_clk = 0;
        repeat (5) @(negedge clk);
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk) mode = m;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr_word(input logic [15:0] w);
        pd_in = w[7:0]; pulse(); pulse();
        pd_in = w[15:8]; pulse(); pulse();
    endtask

    task automatic rd_word(output logic [15:0] w);
        w[7:0] = pd_out; pulse(); pulse();
        w[15:8] = pd_out; pulse(); pulse();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        repeat (4) @(negedge clk);
        chk("R1 oe in reset", {15'd0, pd_oe}, 16'h0000);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R1 oe after reset", {15'd0, pd_oe}, 16'h0000);

        // R1: counter starts at zero without a clear; R6 writes
        set_mode(4'h2);
        wr_word(16'h1234);
        wr_word(16'hA5C3);
        wr_word(16'h0F0F);
        set_mode(4'h1);
        set_mode(4'h3);
        chk("R7 oe in read", {15'd0, pd_oe}, 16'h0001);
        rd_word(w); chk("R1 word0 at reset address", w, 16'h1234);
        rd_word(w); chk("R4 word1", w, 16'hA5C3);
        rd_word(w); chk("R6 word2", w, 16'h0F0F);
        rd_word(w); chk("R1 erased word3", w, 16'hFFFF);

        // R6: rewrite only clears bits
        set_mode(4'h1);
        set_mode(4'h2);
        chk("R7 oe off in write", {15'd0, pd_oe}, 16'h0000);
        wr_word(16'hF0F0);
        set_mode(4'h1);
        set_mode(4'h3);
        rd_word(w); chk("R6 AND rewrite", w, 16'h1030);

        // R8: inhibit and unused encodings ignore pulses
        set_mode(4'h0);
        pd_in = 8'h00;
        repeat (6) pulse();
        set_mode(4'hC);
        repeat (6) pulse();
        set_mode(4'h3);
        rd_word(w); chk("R8 address kept after ignored pulses", w, 16'hA5C3);
        set_mode(4'h1);
        set_mode(4'h3);
        rd_word(w); chk("R8 no write in inhibit", w, 16'h1030);

        // R2: clear in the middle of a cycle
        pulse(); pulse(); pulse();
        set_mode(4'h1);
        set_mode(4'h3);
        rd_word(w); chk("R2 mid-cycle clear", w, 16'h1030);

        // R9: wrap past last location
        set_mode(4'h1);
        set_mode(4'h3);
        for (int i = 0; i < D; i++) rd_word(w);
        chk("R9 last word erased", w, 16'hFFFF);
        rd_word(w); chk("R9 wrap to word0", w, 16'h1030);

        set_mode(4'h0);
        chk("R7 oe released", {15'd0, pd_oe}, 16'h0000);
        chk("R7 bus zero when released", {8'd0, pd_out}, 16'h0000);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule